// File: doc/BRIEF.md
# Predicated SIMD Divide-by-Power-of-Two Shifter

This block divides every 16-bit signed lane of a wide vector by 2^k in one pass, with k an immediate from 1 to 16. The quotient is truncated toward zero, not floored. A non-negative lane takes a plain arithmetic right shift. A negative lane first has a bias of 2^k − 1 added, which pulls its quotient up to the truncated value.

A predicate with one bit per lane selects which lanes are divided. A lane whose bit is clear passes the source value through unchanged, so inactive lanes merge rather than being zeroed. An out-of-range immediate is reported on an error output, and in that case the whole source vector is passed through.

Results are registered one cycle after the input strobe. The vector width is a parameter from 128 to 2048 bits, which gives 8 to 128 lanes.

Top module: `simd_div_pow2`

## Requirements
- R1: Lane i occupies bits [16i+15:16i] of the vector, so lane 0 sits in the least-significant 16 bits. Lane i is governed by predicate bit i.
- R2: An active lane whose value is non-negative produces its value arithmetically shifted right by k.
- R3: An active lane whose value is negative produces its value divided by 2^k and truncated toward zero. This is formed by adding 2^k − 1 in a 17-bit sum and then shifting, so the sum cannot overflow.
- R4: With k = 16, every active lane yields 0. This includes −32768, which gives 0 and not −1.
- R5: An active lane holding −32768 with k = 1 yields −16384.
- R6: A lane whose predicate bit is 0 yields the unchanged source lane.
- R7: An immediate of 0 or of 17 to 31 raises `illegal_o` together with `valid_o`, and the whole result equals the source vector regardless of the predicate.
- R8: `valid_o` is `valid_i` delayed by one clock. `result_o` and `illegal_o` belong to that same accepted input. `result_o` holds its value while no input is accepted, and `illegal_o` is 0 whenever `valid_o` is 0.
- R9: A synchronous active-high reset clears `result_o`, `valid_o` and `illegal_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input strobe; operands are accepted when high |
| src_i | input | VEC_W | Source vector of 16-bit signed lanes |
| pred_i | input | VEC_W/16 | Lane predicate, bit i for lane i |
| shamt_i | input | 5 | Shift immediate k, legal from 1 to 16 |
| result_o | output | VEC_W | Registered result vector |
| valid_o | output | 1 | Registered strobe, one cycle after valid_i |
| illegal_o | output | 1 | Registered flag for an out-of-range immediate |

## Verification
Two decisions act on one lane in the same cycle: the per-lane predicate merge and the vector-wide illegal-immediate override. The bench provokes both at once by applying an out-of-range immediate with a partial predicate. A correct result has every lane equal to the source, whatever its predicate bit, with `illegal_o` high. The same overlap is also exercised at a legal immediate of 16 with −32768 in active and inactive lanes. There the expected output is 0 in active lanes and −32768 in masked ones, and each lane is compared against a truncating division computed in the bench.

// File: rtl/div_pow2_pkg.sv
package div_pow2_pkg;
    localparam int LANE_W  = 16;
    localparam int SUM_W   = LANE_W + 1;
    localparam int IMM_W   = 5;
    localparam int IMM_MIN = 1;
    localparam int IMM_MAX = 16;

    typedef logic signed [LANE_W-1:0] lane_t;
    typedef logic        [IMM_W-1:0]  imm_t;
endpackage

// File: rtl/div_pow2_imm_check.sv
module div_pow2_imm_check
    import div_pow2_pkg::*;
(
    input  imm_t shamt,
    output logic legal
);
    always_comb begin
        legal = (shamt >= imm_t'(IMM_MIN)) && (shamt <= imm_t'(IMM_MAX));
    end
endmodule

// File: rtl/div_pow2_lane.sv
module div_pow2_lane
    import div_pow2_pkg::*;
(
    input  lane_t x,
    input  imm_t  shamt,
    input  logic  active,
    input  logic  legal,
    output lane_t y
);
    logic        [SUM_W-1:0] bias;
    logic signed [SUM_W-1:0] wide;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] shifted;
    lane_t                   quot;

    always_comb begin
        wide    = {x[LANE_W-1], x};
        // negative lanes get 2^k-1 so the shift truncates toward zero (R3)
        bias    = x[LANE_W-1] ? ((SUM_W'(1) << shamt) - SUM_W'(1)) : '0;
        sum     = wide + $signed(bias);
        shifted = sum >>> shamt;
        quot    = shifted[LANE_W-1:0];
        y       = (active && legal) ? quot : x;
    end

    always_comb begin
        if (active && legal) begin
            if (!x[LANE_W-1]) begin
                assert_nonneg_range_R2: assert (y >= 0 && y <= x);
            end else begin
                assert_trunc_range_R3: assert (y <= 0 && y >= x);
            end
            if (shamt == imm_t'(IMM_MAX)) begin
                assert_full_shift_zero_R4: assert (y == 0);
            end
        end else begin
            assert_merge_passthru_R6: assert (y == x);
        end
    end
endmodule

// File: rtl/simd_div_pow2.sv
module simd_div_pow2
    import div_pow2_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_i,
    input  logic [VEC_W-1:0]          src_i,
    input  logic [VEC_W/LANE_W-1:0]   pred_i,
    input  logic [IMM_W-1:0]          shamt_i,
    output logic [VEC_W-1:0]          result_o,
    output logic                      valid_o,
    output logic                      illegal_o
);
    localparam int LANES = VEC_W / LANE_W;

    logic             imm_ok;
    logic [VEC_W-1:0] next_vec;

    div_pow2_imm_check u_imm (
        .shamt (shamt_i),
        .legal (imm_ok)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t lane_y;

        div_pow2_lane u_lane (
            .x      (src_i[g*LANE_W +: LANE_W]),
            .shamt  (shamt_i),
            .active (pred_i[g]),
            .legal  (imm_ok),
            .y      (lane_y)
        );

        assign next_vec[g*LANE_W +: LANE_W] = lane_y;

        assert_inactive_keep_R6: assert property (@(posedge clk) disable iff (rst)
            (valid_i && !pred_i[g]) |=>
                result_o[g*LANE_W +: LANE_W] == $past(src_i[g*LANE_W +: LANE_W]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            valid_o   <= valid_i;
            illegal_o <= valid_i && !imm_ok;
            if (valid_i) begin
                result_o <= next_vec;
            end
        end
    end

    assert_illegal_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (shamt_i == '0 || shamt_i > imm_t'(IMM_MAX))) |=>
            (illegal_o && result_o == $past(src_i)));

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_o == $past(valid_i)));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !$past(rst)) |=> $stable(result_o));

    assert_flag_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> valid_o);

    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> (!valid_o && !illegal_o && result_o == '0));
endmodule

// File: tb/tb_simd_div_pow2.sv
module tb_simd_div_pow2;
    localparam int VW = 128;
    localparam int NL = VW / 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_i;
    logic [VW-1:0] src_i;
    logic [NL-1:0] pred_i;
    logic [4:0]    shamt_i;
    logic [VW-1:0] result_o;
    logic          valid_o;
    logic          illegal_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    simd_div_pow2 #(.VEC_W(VW)) dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .src_i(src_i), .pred_i(pred_i),
        .shamt_i(shamt_i), .result_o(result_o), .valid_o(valid_o), .illegal_o(illegal_o)
    );

    function automatic logic [15:0] model(logic [15:0] x, int k, bit act);
        int xi;
        xi = int'($signed(x));
        if (!act || k < 1 || k > 16) return x;
        return 16'(xi / (1 << k));
    endfunction

    task automatic report(string req, string what, longint got, longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_out(string req, logic [VW-1:0] src, logic [NL-1:0] en, int k);
        bit bad_k;
        bad_k = (k < 1 || k > 16);
        report("R8", {req, " valid_o"}, longint'(valid_o), 1);
        report(bad_k ? "R7" : req, "illegal_o", longint'(illegal_o), longint'(bad_k));
        for (int l = 0; l < NL; l++) begin
            report(req, $sformatf("lane %0d k=%0d", l, k),
                   longint'(result_o[l*16 +: 16]),
                   longint'(model(src[l*16 +: 16], k, en[l])));
        end
    endtask

    task automatic apply(string req, logic [VW-1:0] src, logic [NL-1:0] en, int k);
        @(negedge clk);
        src_i   = src;
        pred_i  = en;
        shamt_i = 5'(k);
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check_out(req, src, en, k);
    endtask

    function automatic logic [VW-1:0] fill(logic [15:0] v);
        logic [VW-1:0] r;
        for (int l = 0; l < NL; l++) r[l*16 +: 16] = v;
        return r;
    endfunction

    task automatic t_reset_r9();
        @(negedge clk);
        report("R9", "result_o after reset", longint'(result_o != '0), 0);
        report("R9", "valid_o after reset", longint'(valid_o), 0);
        report("R9", "illegal_o after reset", longint'(illegal_o), 0);
    endtask

    task automatic t_positive_r2();
        logic [VW-1:0] s;
        for (int k = 1; k <= 16; k++) begin
            for (int l = 0; l < NL; l++) s[l*16 +: 16] = 16'($urandom_range(0, 32767));
            s[15:0] = 16'h7fff;
            apply("R2", s, '1, k);
        end
    endtask

    task automatic t_negative_r3();
        logic [VW-1:0] s;
        for (int k = 1; k <= 16; k++) begin
            for (int l = 0; l < NL; l++) s[l*16 +: 16] = 16'($urandom_range(32768, 65535));
            s[15:0]  = 16'hffff;
            s[31:16] = 16'(-(1 << (k - 1)) - 1);
            apply("R3", s, '1, k);
        end
    endtask

    task automatic t_full_shift_r4();
        logic [VW-1:0] s;
        s = fill(16'h8000);
        s[31:16] = 16'h7fff;
        s[47:32] = 16'hffff;
        apply("R4", s, '1, 16);
    endtask

    task automatic t_min_value_r5();
        apply("R5", fill(16'h8000), '1, 1);
        report("R5", "lane 0 value", longint'(result_o[15:0]), longint'(16'hc000));
    endtask

    task automatic t_lane_order_r1();
        logic [VW-1:0] s;
        for (int l = 0; l < NL; l++) s[l*16 +: 16] = 16'(16'h1000 * (l + 1));
        for (int b = 0; b < NL; b++) apply("R1", s, NL'(1) << b, 4);
    endtask

    task automatic t_predicate_r6();
        logic [VW-1:0] s;
        for (int l = 0; l < NL; l++) s[l*16 +: 16] = 16'($urandom);
        apply("R6", s, NL'(8'ha5), 3);
        apply("R6", s, '0, 7);
    endtask

    task automatic t_illegal_r7();
        logic [VW-1:0] s;
        for (int l = 0; l < NL; l++) s[l*16 +: 16] = 16'($urandom);
        apply("R7", s, '1, 0);
        apply("R7", s, NL'(8'h3c), 17);
        apply("R7", s, '1, 31);
    endtask

    task automatic t_hold_r8();
        logic [VW-1:0] held;
        apply("R8", fill(16'hfff0), '1, 2);
        held = result_o;
        @(negedge clk);
        src_i   = fill(16'h1234);
        shamt_i = 5'd0;
        @(negedge clk);
        report("R8", "valid_o idle", longint'(valid_o), 0);
        report("R8", "illegal_o idle", longint'(illegal_o), 0);
        report("R8", "result_o held", longint'(result_o != held), 0);
    endtask

    task automatic t_overlap_r6_r7();
        logic [VW-1:0] s;
        s = fill(16'h8000);
        s[63:48] = 16'h4321;
        apply("R7", s, NL'(8'h0f), 20);
        apply("R4", s, NL'(8'h33), 16);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; src_i = '0; pred_i = '0; shamt_i = 5'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_r9();
        t_positive_r2();
        t_negative_r3();
        t_full_shift_r4();
        t_min_value_r5();
        t_lane_order_r1();
        t_predicate_r6();
        t_illegal_r7();
        t_hold_r8();
        t_overlap_r6_r7();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule